// File: doc/BRIEF.md
# Replayable Synchronous FIFO with Fill Flags

This block is a first-in first-out buffer of 512 words, each 9 bits wide. Write and read addresses come from internal pointers that step through the storage in order, so the user only raises a write strobe with data or a read strobe. Every operation happens on the single system clock: a strobe that is high at a rising edge is one request. The ninth data bit needs no special handling. It can carry parity or a control marker and is stored and returned exactly as written.

Three flags report the fill level: empty, full and a half-full flag that rises once half of the capacity is in use. A request that the flags forbid is dropped, so the buffer never overflows or underflows. A replay command moves the read side back to the first location written since reset. Everything written since reset can then be read out again in the original order. This lets a consumer fetch a message a second time without the producer sending it again.

Top module: `fifo_replay`

## Requirements
- R1: The buffer holds 512 words of 9 bits. Bit 8 is stored and returned unchanged like the other bits, and 512 accepted writes with no reads fill the buffer.
- R2: Words come out in the order they were accepted. No address input exists.
- R3: A read request while `empty` is 1 is ignored: `rdData` holds its value, the fill level does not change, and the next accepted read returns the oldest stored word.
- R4: A write request while `full` is 1 is ignored: the fill level stays at 512 and no stored word is overwritten. Draining afterwards returns the original words.
- R5: Let the fill level be the number of stored words. `empty` is 1 exactly when the fill level is 0, `full` is 1 exactly when it is 512, and `halfFull` is 1 exactly when it is at least 256. The flags show the level after all operations applied at the previous rising edge.
- R6: When `replay` is 1 at an edge, the read position returns to the first location written since reset, and the fill level becomes the number of words written since reset. Any read or write in that same cycle is ignored. Later reads return those words again in their original order. Replay is defined only while fewer than 512 words have been written since reset.
- R7: While `rst` is 1 at an edge, the buffer empties. After reset, `empty` is 1, `full` and `halfFull` are 0, and `rdData` is 0.
- R8: A read and a write in the same cycle both take effect when the flags allow each one. At `full` only the read is accepted, and at `empty` only the write is accepted.
- R9: `rdData` is registered. It changes at the edge that accepts a read and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wrReq | input | 1 | Write request for this cycle |
| wrData | input | 9 | Word to store |
| rdReq | input | 1 | Read request for this cycle |
| replay | input | 1 | Rewind the read side to the first word written since reset |
| rdData | output | 9 | Last word read, registered |
| empty | output | 1 | No words stored |
| full | output | 1 | 512 words stored |
| halfFull | output | 1 | At least 256 words stored |

## Verification
On every cycle, the assertions check the following. A blocked write or read leaves the pointers and the fill level alone. A balanced read and write keeps the level steady. Replay lands the read pointer on location zero. The flags never contradict each other. `rdData` holds whenever no read is accepted. Only the bench's scenarios, checked against a queue model, can show the rest: that words return in order with bit 8 intact, that the original data survives writes rejected at full, that `halfFull` switches exactly at 256, and that a replay returns the earlier message word for word.

// File: rtl/fifo_replay_pkg.sv
package fifo_replay_pkg;

  // Strobes from the control to the datapath for one cycle
  typedef struct packed {
    logic wrEn;   // store wrData at the write address
    logic rdEn;   // load rdData from the read address
  } fifoStrobes_t;

endpackage

// File: rtl/fifo_replay_ctrl.sv
module fifo_replay_ctrl
  import fifo_replay_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wrReq,
  input  logic                       rdReq,
  input  logic                       replay,
  output fifoStrobes_t               strobes,
  output logic [$clog2(DEPTH)-1:0]   wrAddr,
  output logic [$clog2(DEPTH)-1:0]   rdAddr,
  output logic                       empty,
  output logic                       full,
  output logic                       halfFull
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = ADDR_W + 1;
  localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0]  CNT_HALF = CNT_W'(DEPTH / 2);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0]  fillCount;
  logic              acceptWr, acceptRd;

  function automatic logic [ADDR_W-1:0] stepPtr(input logic [ADDR_W-1:0] p);
    return (p == LAST_ADDR) ? '0 : p + 1'b1;
  endfunction

  // Flags come straight from the registered fill level
  always_comb begin
    empty    = (fillCount == '0);
    full     = (fillCount == CNT_FULL);
    halfFull = (fillCount >= CNT_HALF);
  end

  // A request is accepted only when its flag allows it and no replay is pending
  always_comb begin
    acceptWr = wrReq && !full  && !replay;
    acceptRd = rdReq && !empty && !replay;
    strobes.wrEn = acceptWr;
    strobes.rdEn = acceptRd;
  end

  assign wrAddr = wrPtr;
  assign rdAddr = rdPtr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else if (replay) begin
      rdPtr     <= '0;
      fillCount <= {1'b0, wrPtr};
    end else begin
      if (acceptWr) wrPtr <= stepPtr(wrPtr);
      if (acceptRd) rdPtr <= stepPtr(rdPtr);
      case ({acceptWr, acceptRd})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full && wrReq && !rdReq && !replay) |=> (full && $stable(wrPtr))); // R4

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (empty && rdReq && !wrReq && !replay) |=> (empty && $stable(rdPtr))); // R3

  AST_BOTH_TAKE_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (wrReq && rdReq && !replay && !empty && !full)
      |=> ($stable(fillCount) && !$stable(wrPtr) && !$stable(rdPtr))); // R8

  AST_REPLAY_REWIND: assert property (@(posedge clk) disable iff (rst)
    replay |=> (rdPtr == '0)); // R6

  AST_FLAGS_CONSISTENT: assert property (@(posedge clk) disable iff (rst)
    !(empty && (full || halfFull)) && (!full || halfFull)); // R5

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (empty && !full && !halfFull)); // R7

endmodule

// File: rtl/fifo_replay_store.sv
module fifo_replay_store
  import fifo_replay_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  fifoStrobes_t             strobes,
  input  logic [$clog2(DEPTH)-1:0] wrAddr,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  input  logic [WIDTH-1:0]         wrData,
  output logic [WIDTH-1:0]         rdData
);

  logic [WIDTH-1:0] mem [DEPTH];

  // The storage array has no reset; only the output register does
  always_ff @(posedge clk) begin
    if (strobes.wrEn) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst)               rdData <= '0;
    else if (strobes.rdEn) rdData <= mem[rdAddr];
  end

  AST_RDDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobes.rdEn |=> $stable(rdData)); // R9

endmodule

// File: rtl/fifo_replay.sv
module fifo_replay
  import fifo_replay_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrReq,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdReq,
  input  logic             replay,
  output logic [WIDTH-1:0] rdData,
  output logic             empty,
  output logic             full,
  output logic             halfFull
);

  localparam int ADDR_W = $clog2(DEPTH);

  fifoStrobes_t      strobes;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  fifo_replay_ctrl #(.DEPTH(DEPTH)) ctrl (
    .clk(clk), .rst(rst), .wrReq(wrReq), .rdReq(rdReq), .replay(replay),
    .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .empty(empty), .full(full), .halfFull(halfFull)
  );

  fifo_replay_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) store (
    .clk(clk), .rst(rst), .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: tb/fifo_replay_test.sv
module fifo_replay_test;

  localparam int DEPTH = 512;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrReq = 1'b0, rdReq = 1'b0, replay = 1'b0;
  logic [8:0] wrData = '0;
  logic [8:0] rdData;
  logic       empty, full, halfFull;

  int checks = 0;
  int errors = 0;

  logic [8:0] model[$];
  logic [8:0] history[$];
  logic [8:0] expRd = '0;

  always #4 clk = ~clk;

  fifo_replay uut (
    .clk(clk), .rst(rst), .wrReq(wrReq), .wrData(wrData), .rdReq(rdReq),
    .replay(replay), .rdData(rdData), .empty(empty), .full(full), .halfFull(halfFull)
  );

  function automatic logic [2:0] expFlags(input int level);
    return {level == 0, level == DEPTH, level >= DEPTH / 2};
  endfunction

  task automatic checkOutputs(input string tag);
    logic [2:0] ef;
    ef = expFlags(model.size());
    checks++;
    if ({empty, full, halfFull} !== ef) begin
      errors++;
      $display("FAIL %s flags: got e=%0b f=%0b h=%0b expected e=%0b f=%0b h=%0b (level %0d)",
               tag, empty, full, halfFull, ef[2], ef[1], ef[0], model.size());
    end
    checks++;
    if (rdData !== expRd) begin
      errors++;
      $display("FAIL %s rdData: got %h expected %h", tag, rdData, expRd);
    end
  endtask

  // Called just after a falling edge; applies one cycle of stimulus
  task automatic doCycle(input bit wr, input logic [8:0] d, input bit rd,
                         input bit rp, input string tag);
    int lvl;
    bit aw, ar;
    wrReq = wr; wrData = d; rdReq = rd; replay = rp;
    lvl = model.size();
    aw = wr && !rp && (lvl < DEPTH);
    ar = rd && !rp && (lvl > 0);
    if (rp) begin
      model = history;
    end else begin
      if (ar) expRd = model.pop_front();
      if (aw) begin
        model.push_back(d);
        history.push_back(d);
      end
    end
    @(posedge clk);
    #2;
    checkOutputs(tag);
    @(negedge clk);
    wrReq = 1'b0; rdReq = 1'b0; replay = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    model.delete();
    history.delete();
    expRd = '0;
    rst = 1'b0;
    #1;
    checkOutputs("R7 reset");
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    doReset();

    // R1 R5: fill to capacity, with bit 8 toggling; halfFull checked at each step
    for (int i = 0; i < DEPTH; i++)
      doCycle(1'b1, 9'(i) ^ (i[0] ? 9'h100 : 9'h0aa), 1'b0, 1'b0, "R1/R5 fill");

    // R4: writes at full are dropped
    for (int i = 0; i < 3; i++) doCycle(1'b1, 9'h1ff, 1'b0, 1'b0, "R4 write at full");

    // R8: read and write together at full, only the read takes effect
    doCycle(1'b1, 9'h155, 1'b1, 1'b0, "R8 both at full");

    // R2 R4 R5: drain everything and compare order
    while (model.size() > 0) doCycle(1'b0, '0, 1'b1, 1'b0, "R2/R4 drain");

    // R3: reads at empty are ignored, rdData holds
    for (int i = 0; i < 3; i++) doCycle(1'b0, '0, 1'b1, 1'b0, "R3 read at empty");

    // R8: read and write together at empty, only the write takes effect
    doCycle(1'b1, 9'h1a5, 1'b1, 1'b0, "R8 both at empty");
    doCycle(1'b0, '0, 1'b1, 1'b0, "R8 read back");
    doCycle(1'b0, '0, 1'b1, 1'b0, "R3 empty again");

    // R6: replay after a partial read, with a read and a write in the same cycle
    doReset();
    for (int i = 0; i < 20; i++) doCycle(1'b1, 9'($urandom), 1'b0, 1'b0, "R6 load");
    for (int i = 0; i < 12; i++) doCycle(1'b0, '0, 1'b1, 1'b0, "R6 first pass");
    doCycle(1'b1, 9'h0f0, 1'b1, 1'b1, "R6 replay");
    doCycle(1'b0, '0, 1'b0, 1'b0, "R9 hold");
    for (int i = 0; i < 22; i++) doCycle(1'b0, '0, 1'b1, 1'b0, "R6 second pass");

    // R8 R9 R2: random traffic; replay only while defined
    doReset();
    for (int i = 0; i < 4000; i++) begin
      bit w, r, p;
      w = ($urandom % 100) < 55;
      r = ($urandom % 100) < 50;
      p = (history.size() < DEPTH) && (($urandom % 97) == 0);
      doCycle(w, 9'($urandom), r, p, "R8/R9 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule